// File: doc/BRIEF.md
# Staggered DDR Refresh Sequencer

This block keeps DDR SDRAM contents alive on behalf of a memory controller with up to four ranks. An internal interval counter produces a refresh request every `ivl_i` cycles. Each request adds one to a count of owed refreshes, and that count saturates at a fixed maximum. The block pays one owed refresh at a time. It first closes all banks with a precharge-all, then issues auto-refresh. Both commands go out in three rank groups on consecutive cycles, so the supply sees smaller current steps. After the last group, the block keeps the access arbiter blocked for the recovery time: the base recovery count plus the extended recovery count.

Refreshes are opportunistic. While the arbiter has a request waiting, owed refreshes are postponed. Once the owed count reaches its maximum, a refresh is forced even if requests are waiting. A sequence never starts while an access is still in flight.

On a sleep request the block does one of two things. With self-refresh enabled, it closes all banks and then sends one refresh command to every rank at once with the clock enable low. It keeps the clock enable low until the sleep request drops. With self-refresh disabled, it simply parks and sends no commands. In both sleep modes, interval ticks are not counted.

Top module: `ddr_refresh_seq`

## Requirements
- R1: During and right after reset, all chip selects are high (deselected), RAS/CAS/WE are high, CKE is high and `busy_o` is low.
- R2: A refresh sequence drives precharge-all (RAS=0, CAS=1, WE=0) on three consecutive cycles to rank groups in this order: {CS0, CS3} (`cs_n_o`=4'b0110), then CS1 (4'b1101), then CS2 (4'b1011). It then drives auto-refresh (RAS=0, CAS=0, WE=1) to the same three groups in the same order on the next three cycles.
- R3: The command part of a sequence always lasts six cycles. With zero recovery, `busy_o` is high for exactly six cycles.
- R4: `busy_o` rises in the first precharge-all cycle and stays high for 6 + `rec_i` + `ext_i` cycles in total. Every command cycle occurs while `busy_o` is high.
- R5: A sequence starts only when `acc_idle_i` is high. If refreshes are owed while `acc_idle_i` is low, nothing starts. The sequence begins one clock after `acc_idle_i` goes high.
- R6: While `acc_pend_i` is high, owed refreshes are deferred until the owed count reaches POST_MAX (default 8). At that point a sequence starts one clock later, even though `acc_pend_i` is still high.
- R7: The owed count saturates at POST_MAX. After 20 ticks with no chance to refresh, exactly 8 sequences follow once the block is allowed to refresh.
- R8: With `ivl_i`=N>0, the interval counter produces one tick every N cycles and each tick owes one refresh. With `ivl_i`=0, no ticks occur. With no accesses pending, the first sequence after setting N on an idle counter shows `busy_o` in the (N+1)-th cycle.
- R9: On `sleep_req_i` with `sr_en_i`=1, the block issues the three staggered precharge-all cycles. Next comes one cycle with all chip selects low, RAS=0, CAS=0, WE=1 and CKE=0. After that, CKE stays low with all chip selects high and `busy_o` high while the sleep request is held.
- R10: When the sleep request drops during self-refresh, CKE is high in the next cycle. `busy_o` then stays high for `rec_i` + `ext_i` cycles.
- R11: With `sr_en_i`=0, a sleep request parks the block with no commands, CKE high and `busy_o` high. Interval ticks are ignored in both sleep modes, so no refresh follows the exit from sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ivl_i | input | IVL_W | Refresh interval in cycles, 0 disables ticks |
| rec_i | input | REC_W | Base refresh recovery cycles |
| ext_i | input | EXT_W | Extended refresh recovery cycles |
| acc_pend_i | input | 1 | Arbiter has a request waiting |
| acc_idle_i | input | 1 | No access in flight |
| sleep_req_i | input | 1 | Sleep request |
| sr_en_i | input | 1 | Use self-refresh during sleep |
| cs_n_o | output | NUM_CS | Chip selects, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| busy_o | output | 1 | Arbiter must not grant accesses |

## Verification
The command pins and `busy_o` are decoded from registered state. A decision taken at one rising edge therefore shows up at the falling edge that follows it. An interval tick lands on the edge where the counter reaches N-1, and the first precharge-all appears one edge later. The bench changes inputs and samples outputs only on falling edges, and it counts those samples from the falling edge on which a stimulus was applied. Each expected value is placed at an exact sample count: the (N+1)-th sample for a tick, the 41st sample for a forced refresh at ivl 5, and the next sample for an idle release or a sleep exit. Sequence lengths and rank-group order are compared sample by sample against a vector table.

// File: rtl/ddr_ref_pkg.sv
package ddr_ref_pkg;
  typedef enum logic [2:0] {CMD_NOP, CMD_PRE, CMD_REF, CMD_SRE, CMD_HOLD} cmd_e;
  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_REF, ST_REC, ST_SRE, ST_SR, ST_NOREF} st_e;
endpackage

// File: rtl/ddr_ref_interval.sv
module ddr_ref_interval #(
  parameter int IVL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic             hold_i,
  output logic             tick_o
);
  logic [IVL_W-1:0] cnt_q;
  logic             run;

  assign run    = (ivl_i != '0) && !hold_i;
  // >= so that lowering ivl_i mid-count still wraps promptly
  assign tick_o = run && (cnt_q >= ivl_i - IVL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run || tick_o)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + IVL_W'(1);
  end

  AST_NO_TICK_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ivl_i == '0) |-> !tick_o); // R8
endmodule

// File: rtl/ddr_ref_owed.sv
module ddr_ref_owed #(
  parameter int POST_MAX = 8,
  localparam int OW = $clog2(POST_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic done_i,
  output logic pending_o,
  output logic full_o
);
  logic [OW-1:0] owed_q;

  assign pending_o = owed_q != '0;
  assign full_o    = owed_q == OW'(POST_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         owed_q <= '0;
    else if (tick_i && !done_i && !full_o) owed_q <= owed_q + OW'(1);
    else if (done_i && !tick_i)          owed_q <= owed_q - OW'(1);
  end

  AST_OWED_LE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_q <= OW'(POST_MAX)); // R7
  AST_OWED_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owed_q != $past(owed_q)) |->
      (owed_q == $past(owed_q) + OW'(1) || owed_q == $past(owed_q) - OW'(1))); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> pending_o); // R7
endmodule

// File: rtl/ddr_ref_cmd.sv
module ddr_ref_cmd
  import ddr_ref_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int NGRP   = 3,
  localparam int GW    = $clog2(NGRP),
  localparam int PER_G = (NUM_CS + NGRP - 1) / NGRP
) (
  input  cmd_e              cmd_i,
  input  logic [GW-1:0]     grp_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    localparam logic [GW-1:0] MY_GRP = GW'(i % NGRP);
    always_comb begin
      unique case (cmd_i)
        CMD_PRE, CMD_REF: cs_n_o[i] = (grp_i != MY_GRP);
        CMD_SRE:          cs_n_o[i] = 1'b0;
        default:          cs_n_o[i] = 1'b1;
      endcase
    end
  end

  always_comb begin
    ras_n_o = 1'b1;
    cas_n_o = 1'b1;
    we_n_o  = 1'b1;
    unique case (cmd_i)
      CMD_PRE: begin ras_n_o = 1'b0; we_n_o = 1'b0; end
      CMD_REF, CMD_SRE: begin ras_n_o = 1'b0; cas_n_o = 1'b0; end
      default: ;
    endcase
  end

  assign cke_o = !(cmd_i == CMD_SRE || cmd_i == CMD_HOLD);

  always_comb begin
    if (cke_o) AST_GROUP_LIMIT: assert ($countones(~cs_n_o) <= PER_G); // R2
  end
endmodule

// File: rtl/ddr_refresh_seq.sv
module ddr_refresh_seq
  import ddr_ref_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int NGRP     = 3,
  parameter int IVL_W    = 16,
  parameter int REC_W    = 6,
  parameter int EXT_W    = 4,
  parameter int POST_MAX = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IVL_W-1:0]  ivl_i,
  input  logic [REC_W-1:0]  rec_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic              acc_pend_i,
  input  logic              acc_idle_i,
  input  logic              sleep_req_i,
  input  logic              sr_en_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic              busy_o
);
  localparam int GW    = $clog2(NGRP);
  localparam int SUM_W = ((REC_W > EXT_W) ? REC_W : EXT_W) + 1;
  localparam logic [GW-1:0] LAST = GW'(NGRP - 1);

  st_e              st_q, st_d;
  logic [GW-1:0]    step_q, step_d;
  logic [SUM_W-1:0] rec_q, rec_d, rec_sum;
  logic             tick, pending, full, done, hold;
  cmd_e             cmd;

  assign rec_sum = SUM_W'(rec_i) + SUM_W'(ext_i);
  assign hold    = st_q inside {ST_SRE, ST_SR, ST_NOREF};
  assign done    = (st_q == ST_REF) && (step_q == LAST);
  assign busy_o  = st_q != ST_IDLE;

  ddr_ref_interval #(.IVL_W(IVL_W)) u_ivl (
    .clk_i, .rst_ni, .ivl_i, .hold_i(hold), .tick_o(tick)
  );

  ddr_ref_owed #(.POST_MAX(POST_MAX)) u_owed (
    .clk_i, .rst_ni, .tick_i(tick), .done_i(done),
    .pending_o(pending), .full_o(full)
  );

  // precharge phase is shared by refresh and self-refresh entry; sleep_q picks the exit
  logic sleep_q, sleep_d;

  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    rec_d   = rec_q;
    sleep_d = sleep_q;
    unique case (st_q)
      ST_IDLE: begin
        step_d = '0;
        if (sleep_req_i && acc_idle_i) begin
          sleep_d = 1'b1;
          st_d    = sr_en_i ? ST_PRE : ST_NOREF;
        end else if (pending && acc_idle_i && (!acc_pend_i || full)) begin
          sleep_d = 1'b0;
          st_d    = ST_PRE;
        end
      end
      ST_PRE: begin
        if (step_q == LAST) begin
          step_d = '0;
          st_d   = sleep_q ? ST_SRE : ST_REF;
        end else step_d = step_q + GW'(1);
      end
      ST_REF: begin
        if (step_q == LAST) begin
          step_d = '0;
          rec_d  = rec_sum;
          st_d   = (rec_sum == '0) ? ST_IDLE : ST_REC;
        end else step_d = step_q + GW'(1);
      end
      ST_REC: begin
        rec_d = rec_q - SUM_W'(1);
        if (rec_q <= SUM_W'(1)) st_d = ST_IDLE;
      end
      ST_SRE: st_d = ST_SR;
      ST_SR: begin
        if (!sleep_req_i) begin
          rec_d = rec_sum;
          st_d  = (rec_sum == '0) ? ST_IDLE : ST_REC;
        end
      end
      ST_NOREF: if (!sleep_req_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      step_q  <= '0;
      rec_q   <= '0;
      sleep_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      step_q  <= step_d;
      rec_q   <= rec_d;
      sleep_q <= sleep_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_PRE:  cmd = CMD_PRE;
      ST_REF:  cmd = CMD_REF;
      ST_SRE:  cmd = CMD_SRE;
      ST_SR:   cmd = CMD_HOLD;
      default: cmd = CMD_NOP;
    endcase
  end

  ddr_ref_cmd #(.NUM_CS(NUM_CS), .NGRP(NGRP)) u_cmd (
    .cmd_i(cmd), .grp_i(step_q), .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o, .cke_o
  );

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(acc_idle_i)); // R5
  AST_DEFER_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && $past(acc_pend_i) && !$past(sleep_req_i)) |-> $past(full)); // R6
  AST_CMD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_o != '1) |-> busy_o); // R4
  AST_CKE_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> busy_o); // R9
  AST_SR_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> $past(!sleep_req_i)); // R10
endmodule

// File: tb/ddr_refresh_seq_tb.sv
module ddr_refresh_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ivl;
  logic [5:0]  rec;
  logic [3:0]  ext;
  logic        pend, idle, sleep, sr_en;
  logic [3:0]  cs_n;
  logic        ras_n, cas_n, we_n, cke, busy;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_refresh_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ivl_i(ivl), .rec_i(rec), .ext_i(ext),
    .acc_pend_i(pend), .acc_idle_i(idle), .sleep_req_i(sleep), .sr_en_i(sr_en),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .cke_o(cke), .busy_o(busy)
  );

  // {cs_n[3:0], ras_n, cas_n, we_n} per cycle of a refresh sequence
  localparam logic [6:0] SEQ_TBL [6] = '{
    {4'b0110, 3'b010}, {4'b1101, 3'b010}, {4'b1011, 3'b010},
    {4'b0110, 3'b001}, {4'b1101, 3'b001}, {4'b1011, 3'b001}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_busy(input int lim, output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!busy && k < lim);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic count_ref0(input int cyc, output int n);
    n = 0;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (!cs_n[0] && !ras_n && !cas_n && we_n && cke) n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int k, n, any;
    rst_n = 1'b0; ivl = '0; rec = 6'd10; ext = 4'd3;
    pend = 1'b0; idle = 1'b1; sleep = 1'b0; sr_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {cs_n, ras_n, cas_n, we_n, cke, busy}, 9'b1111_111_1_0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {cs_n, ras_n, cas_n, we_n, cke, busy}, 9'b1111_111_1_0);

    // interval 20: busy due on sample 21, then table walk and recovery 10+3
    ivl = 16'd20;
    wait_busy(60, k);
    ivl = '0;
    chk("R8 first tick timing", k, 21);
    for (int i = 0; i < 6; i++) begin
      if (i > 0) @(negedge clk);
      chk($sformatf("R2 seq step %0d", i), {cs_n, ras_n, cas_n, we_n}, SEQ_TBL[i]);
    end
    busy_len(n);
    chk("R4 busy length rec=10 ext=3", 5 + n, 19);

    // zero recovery: six-cycle sequence
    rec = '0; ext = '0; ivl = 16'd2;
    wait_busy(20, k);
    ivl = '0;
    busy_len(n);
    chk("R3 full length zero recovery", n, 6);
    repeat (20) @(negedge clk);

    // access in flight blocks start
    idle = 1'b0; ivl = 16'd4; any = 0;
    for (int c = 0; c < 12; c++) begin @(negedge clk); if (busy) any++; end
    chk("R5 no start while not idle", any, 0);
    ivl = '0; idle = 1'b1;
    @(negedge clk);
    chk("R5 start one cycle after idle", busy, 1);
    count_ref0(40, n);
    chk("R8 three ticks owed three refreshes", n, 3);

    // posting: forced at 8th tick of ivl 5 despite pending request
    pend = 1'b1; ivl = 16'd5;
    wait_busy(80, k);
    ivl = '0; pend = 1'b0;
    chk("R6 forced at max owed", k, 41);
    count_ref0(80, n);
    chk("R6 owed refreshes paid", n, 8);

    // saturation: 20 ticks, only 8 owed
    idle = 1'b0; pend = 1'b1; ivl = 16'd5;
    repeat (100) @(negedge clk);
    ivl = '0; idle = 1'b1; pend = 1'b0;
    count_ref0(80, n);
    chk("R7 saturated owed count", n, 8);

    // self-refresh entry and exit, recovery 4+1
    rec = 6'd4; ext = 4'd1; sr_en = 1'b1; sleep = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk($sformatf("R9 sleep precharge %0d", i), {cs_n, ras_n, cas_n, we_n}, SEQ_TBL[i]);
    end
    @(negedge clk);
    chk("R9 all-rank entry", {cs_n, ras_n, cas_n, we_n, cke}, 8'b0000_001_0);
    ivl = 16'd3;
    repeat (5) @(negedge clk);
    chk("R9 hold in self-refresh", {cs_n, cke, busy}, 6'b1111_0_1);
    sleep = 1'b0; ivl = '0;
    @(negedge clk);
    chk("R10 cke high on exit", {cke, busy}, 2'b11);
    busy_len(n);
    chk("R10 exit recovery", n, 5);
    any = 0;
    for (int c = 0; c < 30; c++) begin @(negedge clk); if (busy) any++; end
    chk("R11 no refresh after self-refresh", any, 0);

    // sleep without self-refresh
    sr_en = 1'b0; sleep = 1'b1; ivl = 16'd3; any = 0;
    @(negedge clk);
    chk("R11 parked busy", {cs_n, cke, busy}, 6'b1111_1_1);
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (cs_n != 4'hf || !cke) any++;
    end
    chk("R11 no commands in sleep", any, 0);
    sleep = 1'b0; ivl = '0;
    @(negedge clk);
    chk("R11 leave sleep", busy, 0);
    any = 0;
    for (int c = 0; c < 30; c++) begin @(negedge clk); if (busy) any++; end
    chk("R11 ticks ignored in sleep", any, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule